// File: doc/BRIEF.md
# Register window index translator

This block turns an architectural integer register number into an address in a flat physical register file. The file is laid out in three parts. The lowest part holds several banks of eight global registers, and the global level input picks the bank. Above it sits a circular region of sixteen registers per window, and the current window pointer picks the window. At the top sit a few microcode scratch registers. Beyond the ordinary architectural range, two more index ranges reach the window just below and just above the current one, so a single access can read a neighbour's registers. Any index past the last range is reported as invalid.

The unit is purely combinational and has no clock or reset. It sits between register-number decode and the register file read and write ports. The window pointer must be below the window count, and the global level must be at most the maximum level. With the defaults (32 architectural registers, 8 windows, maximum level 3, 9 microcode registers), the file has 32 global entries at 0..31, 128 windowed entries at 32..159 and 9 microcode entries at 160..168. The index input is 7 bits, the window pointer 3 bits, the global level 2 bits and the physical address 8 bits.

Top module: `regwin_xlate`

## Requirements
- R1: An index from 0 to 7 maps to index + 8*level (default: level 3, index 3 gives 27).
- R2: An index from 8 to N_ARCH-1 maps to N_GLOB + ((index - 8 - 16*cwp) mod N_WIN*16), with N_GLOB = 8*(MAX_GL+1) (default: index 8 with cwp 1 gives 144).
- R3: An index from N_ARCH to N_ARCH+N_MICRO-1 maps to index - N_ARCH + N_GLOB + 16*N_WIN (default: 32 gives 160, 40 gives 168).
- R4: The previous-window range is the N_ARCH indices starting at N_ARCH+N_MICRO (default 41..72). Let the local index be the index minus that base. A local index below 8 maps as a global with the current level. Any other local index uses the R2 formula with cwp-1.
- R5: The next-window range is the N_ARCH indices starting at 2*N_ARCH+N_MICRO (default 73..104). Local indices below 8 map as globals. The others use the R2 formula with cwp+1.
- R6: The adjacent-window ranges wrap around the ring. With cwp 0, the previous window is the last window: index 49 gives 48. With cwp N_WIN-1, the next window is window 0: index 81 gives 32.
- R7: An index at or above 3*N_ARCH+N_MICRO (default 105) raises invalid_o, and phys_o is then 0. Below that limit, invalid_o is 0.
- R8: A valid result always lies below N_GLOB+16*N_WIN+N_MICRO (default 169). The outputs depend only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idx_i | input | 7 | Architectural register index, extended ranges included |
| cwp_i | input | 3 | Current window pointer |
| gl_i | input | 2 | Global level, selects the global bank |
| phys_o | output | 8 | Physical register file address |
| invalid_o | output | 1 | Index lies beyond every defined range |

## Verification
The hardest cases to reach are the two wrap points of the ring. One is the previous-window range with the pointer at zero. The other is the next-window range with the pointer at the last window. A wrong modulo or a wrong borrow shows up only in these two cases, and only for local indices of 8 and above. The stimulus first drives both wrap points directly, together with the first and last index of every range and the first invalid index. It then sweeps every index code, including the unused codes above the limit, against every window pointer and every global level. Each result is compared with a behavioural integer model.

// File: rtl/regwin_pkg.sv
`timescale 1ns/1ps
package regwin_pkg;
  typedef enum logic [1:0] {
    REG_GLOBAL,
    REG_WINDOW,
    REG_MICRO,
    REG_BAD
  } reg_kind_e;

  typedef enum logic [1:0] {
    WIN_CUR,
    WIN_PREV,
    WIN_NEXT
  } win_sel_e;
endpackage

// File: rtl/regwin_range_dec.sv
`timescale 1ns/1ps
module regwin_range_dec
  import regwin_pkg::*;
#(
  parameter int N_ARCH  = 32,
  parameter int N_MICRO = 9,
  parameter int IDX_W   = 7
) (
  input  logic [IDX_W-1:0] idx_i,
  output reg_kind_e        kind_o,
  output win_sel_e         sel_o,
  output logic [IDX_W-1:0] loc_o
);
  localparam logic [IDX_W-1:0] G_TOP   = IDX_W'(8);
  localparam logic [IDX_W-1:0] B_MICRO = IDX_W'(N_ARCH);
  localparam logic [IDX_W-1:0] B_PREV  = IDX_W'(N_ARCH + N_MICRO);
  localparam logic [IDX_W-1:0] B_NEXT  = IDX_W'(2 * N_ARCH + N_MICRO);
  localparam logic [IDX_W-1:0] B_LIMIT = IDX_W'(3 * N_ARCH + N_MICRO);

  always_comb begin
    kind_o = REG_BAD;
    sel_o  = WIN_CUR;
    loc_o  = '0;
    if (idx_i < B_MICRO) begin
      loc_o  = idx_i;
      kind_o = (idx_i < G_TOP) ? REG_GLOBAL : REG_WINDOW;
    end else if (idx_i < B_PREV) begin
      loc_o  = idx_i - B_MICRO;
      kind_o = REG_MICRO;
    end else if (idx_i < B_NEXT) begin
      loc_o  = idx_i - B_PREV;
      kind_o = (loc_o < G_TOP) ? REG_GLOBAL : REG_WINDOW;
      sel_o  = WIN_PREV;
    end else if (idx_i < B_LIMIT) begin
      loc_o  = idx_i - B_NEXT;
      kind_o = (loc_o < G_TOP) ? REG_GLOBAL : REG_WINDOW;
      sel_o  = WIN_NEXT;
    end
  end
endmodule

// File: rtl/regwin_win_map.sv
`timescale 1ns/1ps
module regwin_win_map
  import regwin_pkg::*;
#(
  parameter int N_WIN = 8,
  parameter int IDX_W = 7,
  parameter int CWP_W = 3,
  parameter int OFF_W = 7
) (
  input  logic [IDX_W-1:0] loc_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  win_sel_e         sel_i,
  output logic [OFF_W-1:0] off_o
);
  localparam int WIN_SPAN = N_WIN * 16;
  localparam int WW       = IDX_W + CWP_W + 6;
  localparam logic [CWP_W-1:0] LAST = CWP_W'(N_WIN - 1);

  logic [CWP_W-1:0] eff_cwp;
  logic [WW-1:0]    raw;

  // neighbour window = pointer +/-1 around the ring
  always_comb begin
    unique case (sel_i)
      WIN_PREV: eff_cwp = (cwp_i == '0) ? LAST : cwp_i - CWP_W'(1);
      WIN_NEXT: eff_cwp = (cwp_i == LAST) ? '0 : cwp_i + CWP_W'(1);
      default:  eff_cwp = cwp_i;
    endcase
  end

  // bias by one full ring so the difference stays non-negative
  assign raw   = WW'(loc_i) + WW'(WIN_SPAN) - WW'(8) - (WW'(eff_cwp) << 4);
  assign off_o = OFF_W'(raw % WW'(WIN_SPAN));
endmodule

// File: rtl/regwin_xlate.sv
`timescale 1ns/1ps
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int N_ARCH  = 32,
  parameter int N_WIN   = 8,
  parameter int MAX_GL  = 3,
  parameter int N_MICRO = 9,
  localparam int N_GLOB    = (MAX_GL + 1) * 8,
  localparam int WIN_SPAN  = N_WIN * 16,
  localparam int N_PHYS    = N_GLOB + WIN_SPAN + N_MICRO,
  localparam int IDX_LIMIT = 3 * N_ARCH + N_MICRO,
  localparam int IDX_W     = $clog2(IDX_LIMIT + 1),
  localparam int PHYS_W    = $clog2(N_PHYS),
  localparam int CWP_W     = (N_WIN > 1) ? $clog2(N_WIN) : 1,
  localparam int GL_W      = (MAX_GL > 0) ? $clog2(MAX_GL + 1) : 1
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic [GL_W-1:0]   gl_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              invalid_o
);
  localparam int OFF_W = $clog2(WIN_SPAN);

  reg_kind_e        kind;
  win_sel_e         sel;
  logic [IDX_W-1:0] loc;
  logic [OFF_W-1:0] off;

  regwin_range_dec #(
    .N_ARCH (N_ARCH),
    .N_MICRO(N_MICRO),
    .IDX_W  (IDX_W)
  ) u_dec (
    .idx_i (idx_i),
    .kind_o(kind),
    .sel_o (sel),
    .loc_o (loc)
  );

  regwin_win_map #(
    .N_WIN(N_WIN),
    .IDX_W(IDX_W),
    .CWP_W(CWP_W),
    .OFF_W(OFF_W)
  ) u_win (
    .loc_i(loc),
    .cwp_i(cwp_i),
    .sel_i(sel),
    .off_o(off)
  );

  always_comb begin
    unique case (kind)
      REG_GLOBAL: phys_o = PHYS_W'({gl_i, loc[2:0]});
      REG_WINDOW: phys_o = PHYS_W'(N_GLOB) + PHYS_W'(off);
      REG_MICRO:  phys_o = PHYS_W'(N_GLOB + WIN_SPAN) + PHYS_W'(loc);
      default:    phys_o = '0;
    endcase
  end

  assign invalid_o = (kind == REG_BAD);
endmodule

// File: rtl/regwin_xlate_chk.sv
`timescale 1ns/1ps
module regwin_xlate_chk #(
  parameter int N_ARCH  = 32,
  parameter int N_WIN   = 8,
  parameter int MAX_GL  = 3,
  parameter int N_MICRO = 9,
  localparam int N_GLOB    = (MAX_GL + 1) * 8,
  localparam int WIN_SPAN  = N_WIN * 16,
  localparam int N_PHYS    = N_GLOB + WIN_SPAN + N_MICRO,
  localparam int IDX_LIMIT = 3 * N_ARCH + N_MICRO,
  localparam int IDX_W     = $clog2(IDX_LIMIT + 1),
  localparam int PHYS_W    = $clog2(N_PHYS),
  localparam int CWP_W     = (N_WIN > 1) ? $clog2(N_WIN) : 1,
  localparam int GL_W      = (MAX_GL > 0) ? $clog2(MAX_GL + 1) : 1
) (
  input logic [IDX_W-1:0]  idx_i,
  input logic [CWP_W-1:0]  cwp_i,
  input logic [GL_W-1:0]   gl_i,
  input logic [PHYS_W-1:0] phys_o,
  input logic              invalid_o
);
  int i_v, p_v, c_v, g_v;

  always_comb begin
    i_v = int'(idx_i);
    p_v = int'(phys_o);
    c_v = int'(cwp_i);
    g_v = int'(gl_i);
    p_bad_flag_r7: assert (invalid_o == (i_v >= IDX_LIMIT))
      else $error("invalid_o disagrees with index range");
    if (invalid_o) begin
      p_bad_zero_r7: assert (p_v == 0) else $error("phys_o not zero on invalid");
    end
    if (i_v < 8) begin
      p_global_r1: assert (p_v == i_v + 8 * g_v) else $error("global bank mismatch");
    end
    if (i_v >= 8 && i_v < N_ARCH && c_v < N_WIN) begin
      p_window_band_r2: assert (p_v >= N_GLOB && p_v < N_GLOB + WIN_SPAN)
        else $error("window result outside windowed region");
    end
    if (i_v >= N_ARCH && i_v < N_ARCH + N_MICRO) begin
      p_micro_r3: assert (p_v == i_v - N_ARCH + N_GLOB + WIN_SPAN)
        else $error("microcode mapping mismatch");
    end
    if (!invalid_o) begin
      p_in_file_r8: assert (p_v < N_PHYS) else $error("phys_o beyond file");
    end
  end
endmodule

bind regwin_xlate regwin_xlate_chk #(
  .N_ARCH (N_ARCH),
  .N_WIN  (N_WIN),
  .MAX_GL (MAX_GL),
  .N_MICRO(N_MICRO)
) u_chk (
  .idx_i    (idx_i),
  .cwp_i    (cwp_i),
  .gl_i     (gl_i),
  .phys_o   (phys_o),
  .invalid_o(invalid_o)
);

// File: tb/regwin_xlate_tb.sv
`timescale 1ns/1ps
module regwin_xlate_tb;
  localparam int N_ARCH    = 32;
  localparam int N_WIN     = 8;
  localparam int MAX_GL    = 3;
  localparam int N_MICRO   = 9;
  localparam int N_GLOB    = (MAX_GL + 1) * 8;
  localparam int SPAN      = N_WIN * 16;
  localparam int N_PHYS    = N_GLOB + SPAN + N_MICRO;
  localparam int IDX_LIMIT = 3 * N_ARCH + N_MICRO;
  localparam int IDX_W     = $clog2(IDX_LIMIT + 1);
  localparam int PHYS_W    = $clog2(N_PHYS);
  localparam int CWP_W     = $clog2(N_WIN);
  localparam int GL_W      = $clog2(MAX_GL + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [IDX_W-1:0]  idx = '0;
  logic [CWP_W-1:0]  cwp = '0;
  logic [GL_W-1:0]   gl = '0;
  logic [PHYS_W-1:0] phys;
  logic              invalid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  regwin_xlate #(
    .N_ARCH(N_ARCH), .N_WIN(N_WIN), .MAX_GL(MAX_GL), .N_MICRO(N_MICRO)
  ) u_dut (
    .idx_i(idx), .cwp_i(cwp), .gl_i(gl), .phys_o(phys), .invalid_o(invalid)
  );

  function automatic int ring(int loc, int c);
    int v;
    v = (loc - 8 - c * 16 + SPAN) % SPAN;
    if (v < 0) v += SPAN;
    return N_GLOB + v;
  endfunction

  function automatic void model(input int i, input int c, input int g,
                                output int p, output bit inv, output string tag);
    inv = 1'b0;
    p = 0;
    if (i < 8) begin
      p = i + 8 * g; tag = "R1";
    end else if (i < N_ARCH) begin
      p = ring(i, c); tag = "R2";
    end else if (i < N_ARCH + N_MICRO) begin
      p = i - N_ARCH + N_GLOB + SPAN; tag = "R3";
    end else if (i < 2 * N_ARCH + N_MICRO) begin
      int l;
      l = i - (N_ARCH + N_MICRO);
      p = (l < 8) ? l + 8 * g : ring(l, c - 1);
      tag = (l >= 8 && c == 0) ? "R6" : "R4";
    end else if (i < IDX_LIMIT) begin
      int l;
      l = i - (2 * N_ARCH + N_MICRO);
      p = (l < 8) ? l + 8 * g : ring(l, c + 1);
      tag = (l >= 8 && c == N_WIN - 1) ? "R6" : "R5";
    end else begin
      inv = 1'b1; tag = "R7";
    end
  endfunction

  task automatic check(int exp_p, bit exp_inv, string tag);
    n_chk++;
    if (int'(phys) != exp_p || invalid !== exp_inv) begin
      n_fail++;
      $display("FAIL %s idx=%0d cwp=%0d gl=%0d: phys=%0d inv=%0b expected phys=%0d inv=%0b",
               tag, idx, cwp, gl, phys, invalid, exp_p, exp_inv);
    end
  endtask

  task automatic drive(int i, int c, int g);
    @(posedge clk);
    idx = IDX_W'(i);
    cwp = CWP_W'(c);
    gl  = GL_W'(g);
    @(negedge clk);
  endtask

  task automatic directed(int i, int c, int g, int exp_p, bit exp_inv, string tag);
    drive(i, c, g);
    check(exp_p, exp_inv, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(0, 1'b0, "R1 reset state");
    rst_ni = 1'b1;

    directed(3,   0, 3, 27,  1'b0, "R1");
    directed(8,   0, 0, 32,  1'b0, "R2");
    directed(8,   1, 0, 144, 1'b0, "R2");
    directed(31,  0, 0, 55,  1'b0, "R2");
    directed(32,  5, 2, 160, 1'b0, "R3");
    directed(40,  0, 0, 168, 1'b0, "R3");
    directed(44,  0, 2, 19,  1'b0, "R4");
    directed(49,  1, 0, 32,  1'b0, "R4");
    directed(49,  0, 0, 48,  1'b0, "R6");
    directed(81,  7, 0, 32,  1'b0, "R6");
    directed(81,  0, 0, 144, 1'b0, "R5");
    directed(104, 0, 0, 39,  1'b0, "R5");
    directed(105, 0, 0, 0,   1'b1, "R7");
    directed(127, 3, 1, 0,   1'b1, "R7");
    directed(3,   0, 3, 27,  1'b0, "R8 repeat gives same result");

    for (int c = 0; c < N_WIN; c++) begin
      for (int g = 0; g <= MAX_GL; g++) begin
        for (int i = 0; i < (1 << IDX_W); i++) begin
          int    p;
          bit    inv;
          string tag;
          model(i, c, g, p, inv, tag);
          drive(i, c, g);
          check(p, inv, tag);
          if (!invalid) begin
            n_chk++;
            if (int'(phys) >= N_PHYS) begin
              n_fail++;
              $display("FAIL R8 idx=%0d: phys=%0d expected below %0d", i, phys, N_PHYS);
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule